// File: doc/BRIEF.md
# Windowed Register File with Overlapping Parameter Windows

This block is the integer register file of a processor core that passes procedure arguments in registers. Software always sees 32 architectural registers. A current window pointer decides which slice of a larger physical array those registers reach. Eight of them, the globals, are shared by every procedure. The other 24 are split into three groups of eight: ins, locals and outs. These groups belong to the active window.

Neighbouring windows share storage. The eight outs of window `w` are the same physical registers as the eight ins of window `w+1`. A call advances the pointer by one, and a return moves it back by one. Both wrap modulo the window count. Arguments therefore change hands with no copy.

An occupancy state machine counts how many windows are resident. It has three states: `OCC_ONE` (a single window), `OCC_SOME` (more than one, not all) and `OCC_FULL` (every window in use). The transitions are:
- `OCC_ONE` goes to `OCC_SOME` on a call, or straight to `OCC_FULL` when only two windows exist.
- `OCC_SOME` goes to `OCC_FULL` on the call that fills the last window, and back to `OCC_ONE` on the return that leaves one window.
- `OCC_FULL` goes to `OCC_SOME` on a return, or to `OCC_ONE` when only two windows exist.
- A call in `OCC_FULL` raises the overflow trap and the state is kept.
- A return in `OCC_ONE` raises the underflow trap and the state is kept.

The trap handler moves the spilled or refilled window to and from memory. That transfer is outside this block.

Top module: `rwin_regfile`

## Requirements
- R1: After reset the window pointer is 0, all registers read 0, no trap is raised, and one window is resident, so a return in the first cycle raises underflow.
- R2: Architectural addresses are decoded by bits [4:3]: 0 selects a global, 1 an out, 2 a local, 3 an in, and bits [2:0] give the register. A global written in one window reads the same value from every window.
- R3: A call alone (call_i high, ret_i low) sets the window pointer to the next value on the following edge, wrapping from NWIN-1 to 0.
- R4: A return alone sets the window pointer to the previous value on the following edge, wrapping from 0 to NWIN-1.
- R5: Out register k of window w and in register k of window w+1 (mod NWIN) are one register: a value written through either address is read through the other after the matching call or return.
- R6: Locals are private: a local written in one window is not seen at the same address in any other window.
- R7: A call while all NWIN windows are resident raises ovf_trap combinationally in the same cycle. The pointer still advances, and residency stays at NWIN.
- R8: A return while one window is resident raises unf_trap combinationally in the same cycle. The pointer still moves back, and residency stays at one.
- R9: call_i and ret_i high together have no effect: no pointer change, no trap, no change in residency.
- R10: The write is synchronous and uses the mapping of the pointer before any same-cycle call or return. A read of the register being written in the same cycle returns the old value. The new value is read from the next cycle.
- R11: Both read ports decode their addresses independently with the same mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Procedure call strobe |
| ret_i | input | 1 | Procedure return strobe |
| rd_addr_a | input | 5 | Read port A architectural address |
| rd_data_a | output | DW | Read port A data, combinational |
| rd_addr_b | input | 5 | Read port B architectural address |
| rd_data_b | output | DW | Read port B data, combinational |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write architectural address |
| wr_data | input | DW | Write data |
| cwp_o | output | clog2(NWIN) | Current window pointer |
| ovf_trap | output | 1 | Window overflow, spill required |
| unf_trap | output | 1 | Window underflow, fill required |

## Verification
The bench builds the block with NWIN=5, GRP=8 and DW=32. A window count that is not a power of two shows whether the pointer wraps at 4 to 0, instead of at a natural counter rollover. Five windows also let a short run of calls reach `OCC_FULL` and overflow repeatedly, and a run of returns hit underflow from many pointer positions. With that depth the overlap between the last window and window 0 is crossed many times during the random phase. There, writes to outs and ins are read back from the neighbouring window.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

    typedef enum logic [1:0] {
        OCC_ONE  = 2'd0,
        OCC_SOME = 2'd1,
        OCC_FULL = 2'd2
    } occ_e;

    typedef enum logic [1:0] {
        GRP_GLB = 2'd0,
        GRP_OUT = 2'd1,
        GRP_LOC = 2'd2,
        GRP_IN  = 2'd3
    } grp_e;

endpackage

// File: rtl/rwin_map.sv
module rwin_map
    import rwin_pkg::*;
#(
    parameter int NWIN = 6,
    parameter int GRP  = 8,
    parameter int AW   = 5,
    parameter int CW   = 3,
    parameter int PW   = 7
) (
    input  logic [AW-1:0] arch,
    input  logic [CW-1:0] cwp,
    output logic [PW-1:0] phys
);
    localparam int SPAN = 2 * GRP;

    grp_e group;
    int   idx;
    int   win;
    int   nxt;
    int   p;

    always_comb begin
        group = grp_e'(arch[AW-1:AW-2]);
        idx   = int'(arch[AW-3:0]);
        win   = int'(cwp);
        nxt   = (win == NWIN - 1) ? 0 : win + 1;
        unique case (group)
            GRP_GLB: p = idx;
            GRP_OUT: p = GRP + nxt * SPAN + GRP + idx;
            GRP_LOC: p = GRP + win * SPAN + idx;
            GRP_IN:  p = GRP + win * SPAN + GRP + idx;
            default: p = idx;
        endcase
        phys = PW'(p);
    end

endmodule

// File: rtl/rwin_array.sv
module rwin_array #(
    parameter int DEPTH = 104,
    parameter int PW    = 7,
    parameter int DW    = 32,
    parameter int NRD   = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NRD-1:0][PW-1:0]  raddr,
    output logic [NRD-1:0][DW-1:0]  rdata,
    input  logic                    we,
    input  logic [PW-1:0]           waddr,
    input  logic [DW-1:0]           wdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar k = 0; k < NRD; k++) begin : g_rd
        assign rdata[k] = mem[raddr[k]];
    end

endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
    import rwin_pkg::*;
#(
    parameter int NWIN = 6,
    parameter int CW   = 3,
    parameter int RW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          call_i,
    input  logic          ret_i,
    output logic [CW-1:0] cwp,
    output logic [RW-1:0] resident,
    output logic          ovf,
    output logic          unf
);
    localparam logic [CW-1:0] CWP_LAST = CW'(NWIN - 1);
    localparam logic [RW-1:0] RES_MAX  = RW'(NWIN);
    localparam logic [RW-1:0] RES_PRE  = RW'(NWIN - 1);
    localparam logic [RW-1:0] RES_TWO  = RW'(2);

    occ_e          state_q, state_d;
    logic [CW-1:0] cwp_q, cwp_d;
    logic [RW-1:0] res_q, res_d;
    logic          step_up, step_dn;

    assign step_up = call_i & ~ret_i;
    assign step_dn = ret_i & ~call_i;

    always_comb begin
        state_d = state_q;
        res_d   = res_q;
        unique case (state_q)
            OCC_ONE: begin
                if (step_up) begin
                    res_d   = res_q + 1'b1;
                    state_d = (res_q == RES_PRE) ? OCC_FULL : OCC_SOME;
                end
            end
            OCC_SOME: begin
                if (step_up) begin
                    res_d   = res_q + 1'b1;
                    state_d = (res_q == RES_PRE) ? OCC_FULL : OCC_SOME;
                end else if (step_dn) begin
                    res_d   = res_q - 1'b1;
                    state_d = (res_q == RES_TWO) ? OCC_ONE : OCC_SOME;
                end
            end
            OCC_FULL: begin
                if (step_dn) begin
                    res_d   = res_q - 1'b1;
                    state_d = (res_q == RES_TWO) ? OCC_ONE : OCC_SOME;
                end
            end
            default: begin
                state_d = OCC_ONE;
                res_d   = RW'(1);
            end
        endcase

        cwp_d = cwp_q;
        if (step_up)      cwp_d = (cwp_q == CWP_LAST) ? '0 : cwp_q + 1'b1;
        else if (step_dn) cwp_d = (cwp_q == '0) ? CWP_LAST : cwp_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OCC_ONE;
            cwp_q   <= '0;
            res_q   <= RW'(1);
        end else begin
            state_q <= state_d;
            cwp_q   <= cwp_d;
            res_q   <= res_d;
        end
    end

    always_comb begin
        ovf      = step_up && (state_q == OCC_FULL);
        unf      = step_dn && (state_q == OCC_ONE);
        cwp      = cwp_q;
        resident = res_q;
    end

    initial begin
        if (RES_MAX < RES_TWO) $error("window count below two");
    end

endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile #(
    parameter int NWIN = 6,
    parameter int GRP  = 8,
    parameter int DW   = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      call_i,
    input  logic                      ret_i,
    input  logic [$clog2(GRP)+1:0]    rd_addr_a,
    output logic [DW-1:0]             rd_data_a,
    input  logic [$clog2(GRP)+1:0]    rd_addr_b,
    output logic [DW-1:0]             rd_data_b,
    input  logic                      wr_en,
    input  logic [$clog2(GRP)+1:0]    wr_addr,
    input  logic [DW-1:0]             wr_data,
    output logic [$clog2(NWIN)-1:0]   cwp_o,
    output logic                      ovf_trap,
    output logic                      unf_trap
);
    localparam int AW    = $clog2(GRP) + 2;
    localparam int CW    = $clog2(NWIN);
    localparam int RW    = $clog2(NWIN + 1);
    localparam int DEPTH = GRP + 2 * GRP * NWIN;
    localparam int PW    = $clog2(DEPTH);
    localparam int NRD   = 2;

    logic [CW-1:0]           cwp;
    logic [RW-1:0]           resident;
    logic [NRD-1:0][AW-1:0]  rd_arch;
    logic [NRD-1:0][PW-1:0]  rd_phys;
    logic [NRD-1:0][DW-1:0]  rd_val;
    logic [PW-1:0]           wr_phys;

    rwin_ctrl #(.NWIN(NWIN), .CW(CW), .RW(RW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .call_i   (call_i),
        .ret_i    (ret_i),
        .cwp      (cwp),
        .resident (resident),
        .ovf      (ovf_trap),
        .unf      (unf_trap)
    );

    assign rd_arch[0] = rd_addr_a;
    assign rd_arch[1] = rd_addr_b;

    for (genvar k = 0; k < NRD; k++) begin : g_rmap
        rwin_map #(.NWIN(NWIN), .GRP(GRP), .AW(AW), .CW(CW), .PW(PW)) u_map (
            .arch (rd_arch[k]),
            .cwp  (cwp),
            .phys (rd_phys[k])
        );
    end

    rwin_map #(.NWIN(NWIN), .GRP(GRP), .AW(AW), .CW(CW), .PW(PW)) u_wmap (
        .arch (wr_addr),
        .cwp  (cwp),
        .phys (wr_phys)
    );

    rwin_array #(.DEPTH(DEPTH), .PW(PW), .DW(DW), .NRD(NRD)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .raddr (rd_phys),
        .rdata (rd_val),
        .we    (wr_en),
        .waddr (wr_phys),
        .wdata (wr_data)
    );

    assign rd_data_a = rd_val[0];
    assign rd_data_b = rd_val[1];
    assign cwp_o     = cwp;

endmodule

// File: rtl/rwin_regfile_chk.sv
module rwin_regfile_chk #(
    parameter int NWIN = 6,
    parameter int CW   = 3,
    parameter int RW   = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          call_i,
    input logic          ret_i,
    input logic [CW-1:0] cwp_o,
    input logic          ovf_trap,
    input logic          unf_trap,
    input logic [RW-1:0] resident
);
    localparam logic [CW-1:0] LAST = CW'(NWIN - 1);

    // R3: a lone call advances the pointer with wrap
    a_r3_call_step: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i) |=>
            (cwp_o == (($past(cwp_o) == LAST) ? '0 : $past(cwp_o) + 1'b1)));

    // R4: a lone return moves the pointer back with wrap
    a_r4_ret_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i) |=>
            (cwp_o == (($past(cwp_o) == '0) ? LAST : $past(cwp_o) - 1'b1)));

    // R7: overflow only with every window resident, and residency is kept
    a_r7_ovf_full: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |-> (resident == RW'(NWIN)) && call_i);

    a_r7_ovf_keep: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |=> (resident == RW'(NWIN)));

    // R8: underflow only with a single window resident, and residency is kept
    a_r8_unf_single: assert property (@(posedge clk) disable iff (!rst_n)
        unf_trap |-> (resident == RW'(1)) && ret_i);

    a_r8_unf_keep: assert property (@(posedge clk) disable iff (!rst_n)
        unf_trap |=> (resident == RW'(1)));

    // R9: both strobes together leave pointer and residency unchanged, no trap
    a_r9_both_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && ret_i) |-> !ovf_trap && !unf_trap);

    a_r9_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && ret_i) |=> $stable(cwp_o) && $stable(resident));

    // R7, R8: traps are exclusive and residency stays in range
    a_r7_r8_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovf_trap, unf_trap}));

    a_r1_res_range: assert property (@(posedge clk) disable iff (!rst_n)
        (resident >= RW'(1)) && (resident <= RW'(NWIN)));

endmodule

bind rwin_regfile rwin_regfile_chk #(.NWIN(NWIN), .CW(CW), .RW(RW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .call_i   (call_i),
    .ret_i    (ret_i),
    .cwp_o    (cwp_o),
    .ovf_trap (ovf_trap),
    .unf_trap (unf_trap),
    .resident (resident)
);

// File: tb/tb_rwin_regfile.sv
module tb_rwin_regfile;

    localparam int NWIN = 5;
    localparam int GRP  = 8;
    localparam int DW   = 32;
    localparam int CW   = $clog2(NWIN);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          call_i = 1'b0;
    logic          ret_i = 1'b0;
    logic [4:0]    rd_addr_a = '0;
    logic [4:0]    rd_addr_b = '0;
    logic [DW-1:0] rd_data_a;
    logic [DW-1:0] rd_data_b;
    logic          wr_en = 1'b0;
    logic [4:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [CW-1:0] cwp_o;
    logic          ovf_trap;
    logic          unf_trap;

    int n_chk  = 0;
    int n_fail = 0;

    // behavioural model state
    int            cwp_m = 0;
    int            res_m = 1;
    logic [DW-1:0] glb_m [GRP];
    logic [DW-1:0] in_m  [NWIN][GRP];
    logic [DW-1:0] loc_m [NWIN][GRP];

    always #4 clk = ~clk;

    rwin_regfile #(.NWIN(NWIN), .GRP(GRP), .DW(DW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .call_i    (call_i),
        .ret_i     (ret_i),
        .rd_addr_a (rd_addr_a),
        .rd_data_a (rd_data_a),
        .rd_addr_b (rd_addr_b),
        .rd_data_b (rd_data_b),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cwp_o     (cwp_o),
        .ovf_trap  (ovf_trap),
        .unf_trap  (unf_trap)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] model_rd(input logic [4:0] a);
        int k = int'(a[2:0]);
        case (a[4:3])
            2'd0:    return glb_m[k];
            2'd1:    return in_m[(cwp_m + 1) % NWIN][k];
            2'd2:    return loc_m[cwp_m][k];
            default: return in_m[cwp_m][k];
        endcase
    endfunction

    function automatic string grp_tag(input logic [4:0] a);
        case (a[4:3])
            2'd0:    return "R2";
            2'd2:    return "R6";
            default: return "R5";
        endcase
    endfunction

    task automatic model_wr(input logic [4:0] a, input logic [DW-1:0] d);
        int k = int'(a[2:0]);
        case (a[4:3])
            2'd0:    glb_m[k] = d;
            2'd1:    in_m[(cwp_m + 1) % NWIN][k] = d;
            2'd2:    loc_m[cwp_m][k] = d;
            default: in_m[cwp_m][k] = d;
        endcase
    endtask

    task automatic step(input logic c, input logic r, input logic we,
                        input logic [4:0] wa, input logic [DW-1:0] wd,
                        input logic [4:0] ra, input logic [4:0] rb,
                        input string tag);
        @(negedge clk);
        call_i = c; ret_i = r; wr_en = we; wr_addr = wa; wr_data = wd;
        rd_addr_a = ra; rd_addr_b = rb;
        #1;
        chk({tag, " pointer"}, DW'(cwp_o), DW'(cwp_m));
        chk({grp_tag(ra), " ", tag, " read A"}, rd_data_a, model_rd(ra));
        chk({"R11 read B"}, rd_data_b, model_rd(rb));
        chk("R7 ovf_trap", DW'(ovf_trap), DW'(c && !r && res_m == NWIN));
        chk("R8 unf_trap", DW'(unf_trap), DW'(r && !c && res_m == 1));
        @(posedge clk);
        if (we) model_wr(wa, wd);
        if (c && !r) begin
            cwp_m = (cwp_m + 1) % NWIN;
            if (res_m < NWIN) res_m++;
        end else if (r && !c) begin
            cwp_m = (cwp_m + NWIN - 1) % NWIN;
            if (res_m > 1) res_m--;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < GRP; k++) begin
            glb_m[k] = '0;
            for (int w = 0; w < NWIN; w++) begin
                in_m[w][k]  = '0;
                loc_m[w][k] = '0;
            end
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 pointer", DW'(cwp_o), '0);
        chk("R1 ovf", DW'(ovf_trap), '0);
        chk("R1 unf", DW'(unf_trap), '0);
        chk("R1 data", rd_data_a, '0);
        // R1, R8: first return underflows, pointer wraps back (R4)
        step(0, 1, 0, 5'd0, '0, 5'd0, 5'd0, "R1 R8");
        step(0, 0, 0, 5'd0, '0, 5'd0, 5'd0, "R4 wrap");
        step(1, 0, 0, 5'd0, '0, 5'd0, 5'd0, "R3 wrap");
        // R2: global shared across windows
        step(0, 0, 1, 5'd5, 32'hA5A5_0005, 5'd5, 5'd5, "R2");
        step(1, 0, 0, 5'd0, '0, 5'd5, 5'd5, "R3");
        step(0, 0, 0, 5'd0, '0, 5'd5, 5'd5, "R2");
        // R5: out register becomes callee in register
        step(0, 0, 1, 5'd11, 32'h0000_1234, 5'd11, 5'd27, "R5");
        step(1, 0, 0, 5'd0, '0, 5'd27, 5'd11, "R3");
        step(0, 0, 1, 5'd25, 32'hFEED_0001, 5'd27, 5'd25, "R5");
        step(0, 1, 0, 5'd0, '0, 5'd9, 5'd25, "R4");
        step(0, 0, 0, 5'd0, '0, 5'd9, 5'd11, "R5");
        // R6: local private to its window
        step(0, 0, 1, 5'd18, 32'h0BAD_C0DE, 5'd18, 5'd18, "R6");
        step(1, 0, 0, 5'd0, '0, 5'd18, 5'd18, "R6");
        step(0, 1, 0, 5'd0, '0, 5'd18, 5'd18, "R6");
        // R9: simultaneous strobes
        step(1, 1, 0, 5'd0, '0, 5'd18, 5'd18, "R9");
        step(0, 0, 0, 5'd0, '0, 5'd18, 5'd18, "R9");
        // R10: write with same-cycle read sees old data, then new
        step(0, 0, 1, 5'd17, 32'h1111_2222, 5'd17, 5'd17, "R10");
        step(0, 0, 0, 5'd0, '0, 5'd17, 5'd17, "R10");
        // R10: write with same-cycle call uses old pointer
        step(1, 0, 1, 5'd20, 32'h3333_4444, 5'd20, 5'd20, "R10");
        step(0, 1, 0, 5'd0, '0, 5'd20, 5'd20, "R10");
        step(0, 0, 0, 5'd0, '0, 5'd20, 5'd20, "R10");
        // R7: fill every window then call again
        for (int i = 0; i < NWIN + 2; i++)
            step(1, 0, 1, 5'(8 + i % 8), DW'(i + 32'h500), 5'(24 + i % 8), 5'(8 + i % 8), "R3 R7");
        // R8: drain then return again
        for (int i = 0; i < NWIN + 2; i++)
            step(0, 1, 0, 5'd0, '0, 5'(24 + i % 8), 5'(8 + i % 8), "R4 R8");
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            int op = $urandom_range(0, 9);
            logic c = (op < 3) || (op == 9);
            logic r = (op >= 3 && op < 6) || (op == 9);
            step(c, r, 1'($urandom_range(0, 1)), 5'($urandom_range(0, 31)),
                 DW'($urandom), 5'($urandom_range(0, 31)), 5'($urandom_range(0, 31)),
                 "R3 R4 R9");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule